// File: doc/BRIEF.md
# Four-Queue FIFO with Switched Full Flag

This block holds four independent first-in first-out queues in one shared storage array, with one write port and one read port on a common clock. The write side chooses its active queue by presenting an address on a write-address bus together with an address-enable strobe. The upper address bits name a device and the lower bits name a queue. A device that sees its own identity in a strobed address becomes the owner of the write selection. A device that sees another identity gives the selection up. The read side names its queue directly, on every read.

Only the owning device may drive the shared full line. It reports the full status of its selected queue. Up to eight devices can wire their full outputs together, and an external pad buffer is enabled by the block's output-enable. Every queue also has empty, almost-empty and almost-full flags. The threshold offset for those flags is chosen by a strap input that is sampled while master reset is held.

Top module: `multiq_fifo`

## Requirements
- R1: While and right after master reset, every queue reads empty (`empty_n_o` all 0, `ae_n_o` all 0, `af_n_o` all 1), `full_n_o` is 1, `full_oe_o` is 0 and `rd_valid_o` is 0.
- R2: A clock edge with `wr_sel_i` high and `wr_addr_i[4:2]` equal to `DEV_ID` makes this device the owner. Right after that edge, `full_oe_o` is 1 and `full_n_o` shows the status of queue `wr_addr_i[1:0]`.
- R3: A clock edge with `wr_sel_i` high and `wr_addr_i[4:2]` naming a different device drops ownership. After it, `full_oe_o` is 0, and writes are ignored until this device is selected again.
- R4: At a clock edge where `wr_n_i` is low, this device is the owner and the selected queue is not full, the block stores `wr_data_i` in the queue that was selected before that edge.
- R5: A queue holding `DEPTH/4` words drives `full_n_o` low while it is selected. Writes to it are ignored, and the words it holds are left unchanged.
- R6: At a clock edge where `rd_n_i` is low and queue `rd_q_i` is not empty, the oldest word of that queue appears on `rd_data_o`, with `rd_valid_o` high, right after the edge. Each queue keeps its own order.
- R7: A read from an empty queue is ignored. `rd_valid_o` stays low and the queue's flags do not change.
- R8: The offset is `OFF_HI` (128) if `dflt_big_i` is high while `rst` is high, and `OFF_LO` (8) otherwise. Changes on `dflt_big_i` after reset have no effect.
- R9: Right after each edge, `ae_n_o[q]` is low exactly when queue q holds no more words than the offset. `af_n_o[q]` is low exactly when it holds at least `DEPTH/4` minus the offset words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high master reset |
| dflt_big_i | input | 1 | Offset strap, sampled during reset |
| wr_sel_i | input | 1 | Write-address enable strobe |
| wr_addr_i | input | 5 | Device number [4:2] and queue number [1:0] |
| wr_n_i | input | 1 | Active-low write enable |
| wr_data_i | input | 18 | Write data |
| rd_n_i | input | 1 | Active-low read enable |
| rd_q_i | input | 2 | Queue to read |
| rd_data_o | output | 18 | Read data |
| rd_valid_o | output | 1 | High for one cycle after a read that took place |
| full_n_o | output | 1 | Active-low full flag of the selected write queue |
| full_oe_o | output | 1 | Drive enable for the shared full line |
| empty_n_o | output | 4 | Active-low empty flag per queue |
| ae_n_o | output | 4 | Active-low almost-empty flag per queue |
| af_n_o | output | 4 | Active-low almost-full flag per queue |

## Verification
The bench fills a queue to its last slot and then writes one extra word. A design that lets the write past the full check would either wrap the pointer over the oldest data or return the intruding word at the end of the read-back. It probes the exact threshold counts on both sides, so a design that compares with an off-by-one or strict inequality shows the wrong flag value at that count. It selects a foreign device and then writes, which would land data in a queue if the ownership check were missing. It also toggles the strap after reset, which would move the thresholds if the offset were not latched.

// File: rtl/mq_pkg.sv
package mq_pkg;
  typedef enum logic {OFF_SMALL = 1'b0, OFF_LARGE = 1'b1} off_sel_e;

  function automatic int unsigned pick_offset(off_sel_e sel, int unsigned lo, int unsigned hi);
    return (sel == OFF_LARGE) ? hi : lo;
  endfunction
endpackage

// File: rtl/mq_wsel.sv
module mq_wsel #(
  parameter int unsigned QW       = 2,
  parameter int unsigned DEV_BITS = 3,
  parameter int unsigned DEV_ID   = 0,
  localparam int unsigned AW      = DEV_BITS + QW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_i,
  input  logic [AW-1:0] addr_i,
  output logic [QW-1:0] wq_o,
  output logic          own_o
);
  logic hit;
  assign hit = (addr_i[AW-1:QW] == DEV_BITS'(DEV_ID));

  always_ff @(posedge clk) begin
    if (rst) begin
      wq_o  <= '0;
      own_o <= 1'b0;
    end else if (sel_i) begin
      own_o <= hit;
      if (hit) wq_o <= addr_i[QW-1:0];
    end
  end

  AST_SEL_TAKES: assert property (@(posedge clk) disable iff (rst)
    (sel_i && hit) |=> (own_o && wq_o == $past(addr_i[QW-1:0]))); // R2
  AST_SEL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (sel_i && !hit) |=> !own_o); // R3
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sel_i |=> ($stable(own_o) && $stable(wq_o))); // R2
endmodule

// File: rtl/mq_qctl.sv
module mq_qctl #(
  parameter int unsigned QDEPTH = 256,
  localparam int unsigned PW    = $clog2(QDEPTH),
  localparam int unsigned CW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [CW-1:0] off_i,
  output logic [PW-1:0] wptr_o,
  output logic [PW-1:0] rptr_o,
  output logic          wr_ok_o,
  output logic          rd_ok_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ae_n_o,
  output logic          af_n_o
);
  logic [CW-1:0] cnt, cnt_nx;

  assign full_o  = (cnt == CW'(QDEPTH));
  assign empty_o = (cnt == '0);
  assign wr_ok_o = wr_i && !full_o;
  assign rd_ok_o = rd_i && !empty_o;

  always_comb begin
    cnt_nx = cnt;
    if (wr_ok_o && !rd_ok_o) cnt_nx = cnt + 1'b1;
    else if (rd_ok_o && !wr_ok_o) cnt_nx = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      wptr_o <= '0;
      rptr_o <= '0;
      ae_n_o <= 1'b0;
      af_n_o <= 1'b1;
    end else begin
      cnt <= cnt_nx;
      if (wr_ok_o) wptr_o <= wptr_o + 1'b1;
      if (rd_ok_o) rptr_o <= rptr_o + 1'b1;
      ae_n_o <= !(cnt_nx <= off_i);
      af_n_o <= !(cnt_nx >= (CW'(QDEPTH) - off_i));
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(QDEPTH)); // R5
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (full_o && wr_i && !rd_i) |=> (full_o && $stable(wptr_o))); // R5
  AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (empty_o && rd_i) |=> $stable(rptr_o)); // R7
endmodule

// File: rtl/mq_ram.sv
module mq_ram #(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 10,
  localparam int unsigned WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/multiq_fifo.sv
module multiq_fifo #(
  parameter int unsigned DW       = 18,
  parameter int unsigned NQ       = 4,
  parameter int unsigned DEPTH    = 1024,
  parameter int unsigned DEV_BITS = 3,
  parameter int unsigned DEV_ID   = 0,
  parameter int unsigned OFF_LO   = 8,
  parameter int unsigned OFF_HI   = 128,
  localparam int unsigned QDEPTH  = DEPTH / NQ,
  localparam int unsigned QW      = $clog2(NQ),
  localparam int unsigned PW      = $clog2(QDEPTH),
  localparam int unsigned CW      = PW + 1,
  localparam int unsigned MAW     = QW + PW,
  localparam int unsigned AW      = DEV_BITS + QW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dflt_big_i,
  input  logic          wr_sel_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_n_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_n_i,
  input  logic [QW-1:0] rd_q_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          full_n_o,
  output logic          full_oe_o,
  output logic [NQ-1:0] empty_n_o,
  output logic [NQ-1:0] ae_n_o,
  output logic [NQ-1:0] af_n_o
);
  import mq_pkg::*;

  logic [CW-1:0] off_r;
  logic [QW-1:0] wq;
  logic          own;
  logic [PW-1:0] wptr [NQ];
  logic [PW-1:0] rptr [NQ];
  logic [NQ-1:0] wr_req, rd_req, wr_ok, rd_ok, full, empty;

  always_ff @(posedge clk) begin
    if (rst) off_r <= CW'(pick_offset(off_sel_e'(dflt_big_i), OFF_LO, OFF_HI));
  end

  mq_wsel #(.QW(QW), .DEV_BITS(DEV_BITS), .DEV_ID(DEV_ID)) u_wsel (
    .clk(clk), .rst(rst), .sel_i(wr_sel_i), .addr_i(wr_addr_i),
    .wq_o(wq), .own_o(own)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign wr_req[q] = own && !wr_n_i && (wq == QW'(q));
    assign rd_req[q] = !rd_n_i && (rd_q_i == QW'(q));
    assign empty_n_o[q] = !empty[q];

    mq_qctl #(.QDEPTH(QDEPTH)) u_qctl (
      .clk(clk), .rst(rst), .wr_i(wr_req[q]), .rd_i(rd_req[q]), .off_i(off_r),
      .wptr_o(wptr[q]), .rptr_o(rptr[q]), .wr_ok_o(wr_ok[q]), .rd_ok_o(rd_ok[q]),
      .full_o(full[q]), .empty_o(empty[q]), .ae_n_o(ae_n_o[q]), .af_n_o(af_n_o[q])
    );
  end

  mq_ram #(.DW(DW), .AW(MAW)) u_ram (
    .clk(clk),
    .we_i(|wr_ok), .waddr_i({wq, wptr[wq]}), .wdata_i(wr_data_i),
    .re_i(|rd_ok), .raddr_i({rd_q_i, rptr[rd_q_i]}), .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid_o <= 1'b0;
    else     rd_valid_o <= |rd_ok;
  end

  assign full_n_o  = !full[wq];
  assign full_oe_o = own;

  AST_RDV_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(!rd_n_i)); // R6
  AST_NO_DRIVE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !full_oe_o |-> (wr_ok == '0)); // R3
endmodule

// File: tb/tb_multiq_fifo.sv
`timescale 1ns/1ps
module tb_multiq_fifo;
  localparam int QD = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dflt_big_i = 1'b0;
  logic wr_sel_i = 1'b0;
  logic [4:0] wr_addr_i = '0;
  logic wr_n_i = 1'b1;
  logic [17:0] wr_data_i = '0;
  logic rd_n_i = 1'b1;
  logic [1:0] rd_q_i = '0;
  logic [17:0] rd_data_o;
  logic rd_valid_o, full_n_o, full_oe_o;
  logic [3:0] empty_n_o, ae_n_o, af_n_o;

  int errors = 0;
  int checks = 0;
  bit m_own;
  int m_wq;
  int m_cnt [4];
  int m_wi [4];
  int m_ri [4];

  always #5 clk = ~clk;

  multiq_fifo dut (
    .clk(clk), .rst(rst), .dflt_big_i(dflt_big_i), .wr_sel_i(wr_sel_i),
    .wr_addr_i(wr_addr_i), .wr_n_i(wr_n_i), .wr_data_i(wr_data_i),
    .rd_n_i(rd_n_i), .rd_q_i(rd_q_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .full_n_o(full_n_o), .full_oe_o(full_oe_o),
    .empty_n_o(empty_n_o), .ae_n_o(ae_n_o), .af_n_o(af_n_o)
  );

  function automatic logic [17:0] pat(int q, int i);
    return {q[1:0], i[15:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic big);
    rst = 1'b1;
    dflt_big_i = big;
    wr_sel_i = 0; wr_n_i = 1; rd_n_i = 1;
    repeat (3) step();
    rst = 1'b0;
    m_own = 0; m_wq = 0;
    for (int q = 0; q < 4; q++) begin m_cnt[q] = 0; m_wi[q] = 0; m_ri[q] = 0; end
  endtask

  task automatic select(input int dev, input int q);
    wr_sel_i = 1; wr_addr_i = {dev[2:0], q[1:0]};
    step();
    wr_sel_i = 0;
    m_own = (dev == 0);
    if (m_own) m_wq = q;
  endtask

  task automatic wr_raw(input logic [17:0] d);
    wr_n_i = 0; wr_data_i = d;
    step();
    wr_n_i = 1;
    if (m_own && m_cnt[m_wq] < QD) begin
      m_cnt[m_wq]++; m_wi[m_wq]++;
    end
  endtask

  task automatic wr_next();
    wr_raw(pat(m_wq, m_wi[m_wq]));
  endtask

  task automatic rd_one(input int q, input string tag);
    rd_n_i = 0; rd_q_i = q[1:0];
    step();
    rd_n_i = 1;
    if (m_cnt[q] > 0) begin
      chk(tag, {31'd0, rd_valid_o}, 1);
      chk(tag, {14'd0, rd_data_o}, {14'd0, pat(q, m_ri[q])});
      m_cnt[q]--; m_ri[q]++;
    end else begin
      chk(tag, {31'd0, rd_valid_o}, 0);
    end
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R1 empty_n", {28'd0, empty_n_o}, 0);
    chk("R1 ae_n", {28'd0, ae_n_o}, 0);
    chk("R1 af_n", {28'd0, af_n_o}, 32'hF);
    chk("R1 full_n", {31'd0, full_n_o}, 1);
    chk("R1 full_oe", {31'd0, full_oe_o}, 0);
    chk("R1 rd_valid", {31'd0, rd_valid_o}, 0);
  endtask

  task automatic t_select();
    select(0, 1);
    chk("R2 oe after select", {31'd0, full_oe_o}, 1);
    chk("R2 full_n new queue", {31'd0, full_n_o}, 1);
  endtask

  task automatic t_foreign();
    select(5, 1);
    chk("R3 oe released", {31'd0, full_oe_o}, 0);
    wr_raw(18'h2AAAA);
    chk("R3 write ignored", {28'd0, empty_n_o}, 0);
    select(0, 1);
    chk("R3 reselected oe", {31'd0, full_oe_o}, 1);
    rd_one(1, "R3 read after foreign write");
  endtask

  task automatic t_order();
    select(0, 2);
    for (int i = 0; i < 3; i++) wr_next();
    select(0, 3);
    wr_next();
    chk("R4 empty_n after writes", {28'd0, empty_n_o}, 32'hC);
    for (int i = 0; i < 3; i++) rd_one(2, "R6 queue2 order");
    rd_one(3, "R6 queue3");
    chk("R6 all empty", {28'd0, empty_n_o}, 0);
  endtask

  task automatic t_empty_read();
    rd_one(0, "R7 empty read");
    chk("R7 flags unchanged", {28'd0, empty_n_o}, 0);
    chk("R7 ae unchanged", {28'd0, ae_n_o}, 0);
  endtask

  task automatic t_small_thresholds();
    select(0, 0);
    for (int i = 0; i < 8; i++) wr_next();
    chk("R9 ae at 8", {31'd0, ae_n_o[0]}, 0);
    wr_next();
    chk("R9 ae at 9", {31'd0, ae_n_o[0]}, 1);
    while (m_cnt[0] < QD - 9) wr_next();
    chk("R9 af at 247", {31'd0, af_n_o[0]}, 1);
    wr_next();
    chk("R9 af at 248", {31'd0, af_n_o[0]}, 0);
    while (m_cnt[0] < QD - 1) wr_next();
    chk("R5 not full at 255", {31'd0, full_n_o}, 1);
    wr_next();
    chk("R5 full at 256", {31'd0, full_n_o}, 0);
    wr_raw(18'h3FFFF);
    chk("R5 still full", {31'd0, full_n_o}, 0);
    select(0, 1);
    chk("R2 switch to non-full queue", {31'd0, full_n_o}, 1);
    select(0, 0);
    chk("R2 switch back to full queue", {31'd0, full_n_o}, 0);
    while (m_cnt[0] > 0) rd_one(0, "R5 contents intact");
    rd_one(0, "R5 no extra word");
    chk("R5 empty after drain", {31'd0, empty_n_o[0]}, 0);
  endtask

  task automatic t_big_offset();
    do_reset(1'b1);
    dflt_big_i = 1'b0;
    select(0, 0);
    for (int i = 0; i < 128; i++) wr_next();
    chk("R8 ae at 128", {31'd0, ae_n_o[0]}, 0);
    chk("R8 af at 128", {31'd0, af_n_o[0]}, 0);
    wr_next();
    chk("R8 ae at 129", {31'd0, ae_n_o[0]}, 1);
    rd_one(0, "R8 read");
    rd_one(0, "R8 read");
    chk("R8 af at 127", {31'd0, af_n_o[0]}, 1);
    chk("R8 ae at 127", {31'd0, ae_n_o[0]}, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_select();
    t_foreign();
    t_order();
    t_empty_read();
    t_small_thresholds();
    t_big_offset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule